// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Instruction Unit

This block is a sequential extension unit that sits beside a 32-bit processor ALU. When the processor issues the instruction it raises `start` for one cycle. In that same cycle it places two operands and an 11-bit command word on the inputs. The unit multiplies the operands and adds the low 32 bits of the product to a running total held inside the block. It shows the new total on `result` a fixed number of qualified clock edges later. There is no done or ready signal. The processor simply reads `result` at the agreed cycle. Because the total survives from one issue to the next, each answer depends on every earlier call since the last clear.

The command word selects one of three actions: accumulate, clear-then-accumulate, or clear only. Work moves through three registered stages: capture, a two-step multiply, and accumulate. A new instruction may therefore be issued on every qualified edge. A clock qualifier freezes the whole pipeline, and an asynchronous reset empties it.

Top module: `mac_unit`

## Requirements
- R1: While `rst` is high, `result` and the running total are zero, and any instruction still in flight is discarded.
- R2: `dataa`, `datab` and `prefix` are sampled only on a rising edge where both `start` and `clk_en` are high. Values they carry on any other edge have no effect on `result`.
- R3: A rising edge with `clk_en` low changes no state. An instruction in flight does not advance, `result` holds, and a `start` on that edge is ignored.
- R4: With `prefix[1:0]` = 00, the total becomes total + (`dataa` * `datab`) mod 2^32. The low 32 bits of the product are the same for signed and unsigned operands, and the sum wraps modulo 2^32. The new total appears on `result` right after the third qualified edge that follows the issuing edge.
- R5: With `prefix[0]` = 1 and `prefix[1]` = 0, the total is cleared before the add, so the result equals the product alone.
- R6: With `prefix[1]` = 1, the total and `result` become zero and the product is discarded, whatever the value of `prefix[0]`. Bits 10 to 2 of `prefix` are reserved and have no effect.
- R7: `result` changes only on the qualified edge where an instruction completes, or on reset. It holds its value until then.
- R8: Instructions issued on consecutive qualified edges are all accepted. They complete in issue order on consecutive qualified edges, and each one sees the total left by the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Asynchronous system reset, active high |
| clk_en | input | 1 | Clock qualifier; edges with it low are ignored |
| start | input | 1 | Issue strobe, high for the issuing cycle |
| dataa | input | 32 | First operand, valid only with `start` |
| datab | input | 32 | Second operand, valid only with `start` |
| prefix | input | 11 | Command word, valid only with `start`; bit 0 clear-then-add, bit 1 clear only |
| result | output | 32 | Running total, presented three qualified edges after issue |

## Verification
Two things can happen in the same cycle. An instruction can complete and update the total in the accumulate stage while a later instruction is being captured. A clear command can complete while accumulating instructions are still behind it in the multiply stages. Both cases are provoked by issuing bursts on consecutive edges, with clear and clear-only commands placed in the middle of a burst. Random runs add `clk_en` gaps and frequent issues so that completions land next to new captures with varying spacing. The outcome is judged by a scoreboard that updates its own total in issue order and advances its own three-entry pipeline only on qualified edges. After every edge it compares `result` against that model's value.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned CMD_CLR_ADD_BIT  = 0;
    localparam int unsigned CMD_CLR_ONLY_BIT = 1;

    typedef struct packed {
        logic clr_add;
        logic clr_only;
    } mac_op_t;

    function automatic mac_op_t mac_decode(input logic [1:0] cmd_bits);
        mac_op_t op;
        op.clr_only = cmd_bits[CMD_CLR_ONLY_BIT];
        op.clr_add  = cmd_bits[CMD_CLR_ADD_BIT] & ~cmd_bits[CMD_CLR_ONLY_BIT];
        return op;
    endfunction

endpackage

// File: rtl/mac_issue_stage.sv
module mac_issue_stage #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CMD_W  = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 start,
    input  logic [DATA_W-1:0]    opa,
    input  logic [DATA_W-1:0]    opb,
    input  logic [CMD_W-1:0]     cmd,
    output logic                 cap_v,
    output logic [DATA_W-1:0]    cap_a,
    output logic [DATA_W-1:0]    cap_b,
    output mac_pkg::mac_op_t     cap_op
);

    typedef struct packed {
        logic                 v;
        logic [DATA_W-1:0]    a;
        logic [DATA_W-1:0]    b;
        mac_pkg::mac_op_t     op;
    } cap_t;

    cap_t cap_d, cap_q;

    logic unused_rsvd_cmd;
    assign unused_rsvd_cmd = ^cmd[CMD_W-1:2];

    always_comb begin
        cap_d = cap_q;
        if (en) begin
            cap_d.v = start;
            if (start) begin
                cap_d.a  = opa;
                cap_d.b  = opb;
                cap_d.op = mac_pkg::mac_decode(cmd[1:0]);
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap_v  = cap_q.v;
    assign cap_a  = cap_q.a;
    assign cap_b  = cap_q.b;
    assign cap_op = cap_q.op;

endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage #(
    parameter int unsigned DATA_W    = 32,
    parameter bit          SPLIT_MUL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 in_v,
    input  logic [DATA_W-1:0]    in_a,
    input  logic [DATA_W-1:0]    in_b,
    input  mac_pkg::mac_op_t     in_op,
    output logic                 out_v,
    output logic [DATA_W-1:0]    out_prod,
    output mac_pkg::mac_op_t     out_op
);

    localparam int unsigned HALF_W = DATA_W / 2;

    typedef struct packed {
        logic                 v;
        mac_pkg::mac_op_t     op;
        logic [DATA_W-1:0]    prod;
    } prod_t;

    prod_t fin_d, fin_q;

    generate
        if (SPLIT_MUL) begin : g_split
            typedef struct packed {
                logic                 v;
                mac_pkg::mac_op_t     op;
                logic [DATA_W-1:0]    pp_lo;
                logic [DATA_W-1:0]    pp_cross;
            } part_t;

            part_t part_d, part_q;
            logic [DATA_W-1:0] a_lo_ext;
            logic [DATA_W-1:0] a_hi_ext;
            logic [DATA_W-1:0] b_lo_ext;
            logic [DATA_W-1:0] cross_raw;

            assign a_lo_ext  = {{(DATA_W-HALF_W){1'b0}}, in_a[HALF_W-1:0]};
            assign a_hi_ext  = {{HALF_W{1'b0}}, in_a[DATA_W-1:HALF_W]};
            assign b_lo_ext  = {{(DATA_W-HALF_W){1'b0}}, in_b[HALF_W-1:0]};
            assign cross_raw = a_hi_ext * b_lo_ext;

            always_comb begin
                part_d = part_q;
                fin_d  = fin_q;
                if (en) begin
                    part_d.v        = in_v;
                    part_d.op       = in_op;
                    part_d.pp_lo    = a_lo_ext * in_b;
                    part_d.pp_cross = cross_raw << HALF_W;
                    fin_d.v         = part_q.v;
                    fin_d.op        = part_q.op;
                    fin_d.prod      = part_q.pp_lo + part_q.pp_cross;
                end
            end

            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    part_q <= '0;
                    fin_q  <= '0;
                end else begin
                    part_q <= part_d;
                    fin_q  <= fin_d;
                end
            end
        end else begin : g_whole
            prod_t mid_d, mid_q;

            always_comb begin
                mid_d = mid_q;
                fin_d = fin_q;
                if (en) begin
                    mid_d.v    = in_v;
                    mid_d.op   = in_op;
                    mid_d.prod = in_a * in_b;
                    fin_d      = mid_q;
                end
            end

            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    mid_q <= '0;
                    fin_q <= '0;
                end else begin
                    mid_q <= mid_d;
                    fin_q <= fin_d;
                end
            end
        end
    endgenerate

    assign out_v    = fin_q.v;
    assign out_prod = fin_q.prod;
    assign out_op   = fin_q.op;

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 in_v,
    input  logic [DATA_W-1:0]    in_prod,
    input  mac_pkg::mac_op_t     in_op,
    output logic [DATA_W-1:0]    total
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [DATA_W-1:0] base;

    always_comb begin
        base = in_op.clr_add ? '0 : acc_q.acc;
    end

    always_comb begin
        acc_d = acc_q;
        if (en && in_v) begin
            if (in_op.clr_only) begin
                acc_d.acc = '0;
            end else begin
                acc_d.acc = base + in_prod;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign total = acc_q.acc;

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CMD_W     = 11,
    parameter bit          SPLIT_MUL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clk_en,
    input  logic                 start,
    input  logic [DATA_W-1:0]    dataa,
    input  logic [DATA_W-1:0]    datab,
    input  logic [CMD_W-1:0]     prefix,
    output logic [DATA_W-1:0]    result
);

    logic                 cap_v;
    logic [DATA_W-1:0]    cap_a;
    logic [DATA_W-1:0]    cap_b;
    mac_pkg::mac_op_t     cap_op;

    logic                 mul_v;
    logic [DATA_W-1:0]    mul_prod;
    mac_pkg::mac_op_t     mul_op;

    mac_issue_stage #(
        .DATA_W (DATA_W),
        .CMD_W  (CMD_W)
    ) issue_i (
        .clk    (clk),
        .rst    (rst),
        .en     (clk_en),
        .start  (start),
        .opa    (dataa),
        .opb    (datab),
        .cmd    (prefix),
        .cap_v  (cap_v),
        .cap_a  (cap_a),
        .cap_b  (cap_b),
        .cap_op (cap_op)
    );

    mac_mul_stage #(
        .DATA_W    (DATA_W),
        .SPLIT_MUL (SPLIT_MUL)
    ) mul_i (
        .clk      (clk),
        .rst      (rst),
        .en       (clk_en),
        .in_v     (cap_v),
        .in_a     (cap_a),
        .in_b     (cap_b),
        .in_op    (cap_op),
        .out_v    (mul_v),
        .out_prod (mul_prod),
        .out_op   (mul_op)
    );

    mac_acc_stage #(
        .DATA_W (DATA_W)
    ) acc_i (
        .clk     (clk),
        .rst     (rst),
        .en      (clk_en),
        .in_v    (mul_v),
        .in_prod (mul_prod),
        .in_op   (mul_op),
        .total   (result)
    );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CMD_W  = 11
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clk_en,
    input logic                 start,
    input logic [DATA_W-1:0]    dataa,
    input logic [DATA_W-1:0]    datab,
    input logic [CMD_W-1:0]     prefix,
    input logic [DATA_W-1:0]    result
);

    logic [2:0]        ck_v;
    logic [2:0]        ck_ca;
    logic [2:0]        ck_co;
    logic [DATA_W-1:0] ck_prod [3];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ck_v  <= '0;
            ck_ca <= '0;
            ck_co <= '0;
            for (int i = 0; i < 3; i++) ck_prod[i] <= '0;
        end else if (clk_en) begin
            ck_v  <= {ck_v[1:0], start};
            ck_ca <= {ck_ca[1:0], prefix[0]};
            ck_co <= {ck_co[1:0], prefix[1]};
            ck_prod[0] <= dataa * datab;
            ck_prod[1] <= ck_prod[0];
            ck_prod[2] <= ck_prod[1];
        end
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |-> result == '0);

    a_r3_en_low_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(result));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !ck_v[2]) |=> $stable(result));

    a_r6_clear_only: assert property (@(posedge clk) disable iff (rst)
        (clk_en && ck_v[2] && ck_co[2]) |=> result == '0);

    a_r5_clear_add: assert property (@(posedge clk) disable iff (rst)
        (clk_en && ck_v[2] && ck_ca[2] && !ck_co[2]) |=> result == $past(ck_prod[2]));

    a_r4_accumulate: assert property (@(posedge clk) disable iff (rst)
        (clk_en && ck_v[2] && !ck_ca[2] && !ck_co[2])
            |=> result == $past(result) + $past(ck_prod[2]));

endmodule

bind mac_unit mac_unit_chk #(
    .DATA_W (DATA_W),
    .CMD_W  (CMD_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .start  (start),
    .dataa  (dataa),
    .datab  (datab),
    .prefix (prefix),
    .result (result)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        clk_en;
    logic        start;
    logic [31:0] dataa;
    logic [31:0] datab;
    logic [10:0] prefix;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mac_unit dut_i (
        .clk    (clk),
        .rst    (rst),
        .clk_en (clk_en),
        .start  (start),
        .dataa  (dataa),
        .datab  (datab),
        .prefix (prefix),
        .result (result)
    );

    // scoreboard model
    bit          mv   [3];
    logic [31:0] mval [3];
    string       mtag [3];
    logic [31:0] macc = '0;
    logic [31:0] exp_res = '0;
    string       cur_tag = "R1";
    string       phase_tag = "";

    function automatic logic [31:0] next_total(input logic [31:0] acc,
                                               input logic [31:0] a,
                                               input logic [31:0] b,
                                               input logic [10:0] p);
        logic [31:0] prod;
        prod = a * b;
        if (p[1])      return 32'd0;
        else if (p[0]) return prod;
        else           return acc + prod;
    endfunction

    function automatic string tag_for(input logic [10:0] p);
        if (p[1])      return "R6";
        else if (p[0]) return "R5";
        else           return "R4";
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s result=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit          ret_v;
        logic [31:0] ret_val;
        string       ret_tag;
        if (rst) begin
            for (int i = 0; i < 3; i++) mv[i] = 1'b0;
            macc    = '0;
            exp_res = '0;
            cur_tag = "R1";
        end else if (clk_en) begin
            ret_v   = mv[2];
            ret_val = mval[2];
            ret_tag = mtag[2];
            for (int i = 2; i > 0; i--) begin
                mv[i]   = mv[i-1];
                mval[i] = mval[i-1];
                mtag[i] = mtag[i-1];
            end
            mv[0] = start;
            if (start) begin
                macc    = next_total(macc, dataa, datab, prefix);
                mval[0] = macc;
                mtag[0] = (phase_tag != "") ? phase_tag : tag_for(prefix);
            end
            if (ret_v) begin
                exp_res = ret_val;
                cur_tag = ret_tag;
            end else begin
                cur_tag = "R7";
            end
        end else begin
            cur_tag = "R3";
        end
        #1;
        check(cur_tag, result, exp_res);
    end

    task automatic garble();
        dataa  = $urandom;
        datab  = $urandom;
        prefix = 11'($urandom);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start  = 1'b0;
            clk_en = 1'b1;
            garble();
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [10:0] p, input logic en);
        @(negedge clk);
        start  = 1'b1;
        clk_en = en;
        dataa  = a;
        datab  = b;
        prefix = p;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst    = 1'b0;
        clk_en = 1'b1;
        start  = 1'b0;
        dataa  = '0;
        datab  = '0;
        prefix = '0;
        #1 rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", result, 32'd0);   // R1 reset state
        idle(2);

        // R4 plain accumulate, signed operand
        issue(32'd3, 32'd5, 11'd0, 1'b1);
        issue(32'd7, 32'hFFFF_FFFE, 11'd0, 1'b1);
        idle(5);
        check("R4", result, 32'd1);

        // R4 wrap-around cases
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 11'd0, 1'b1);
        issue(32'h8000_0000, 32'd2, 11'd0, 1'b1);
        issue(32'h0001_0000, 32'h0001_0000, 11'd0, 1'b1);
        issue(32'hFFFF_FFFF, 32'd1, 11'd0, 1'b1);
        idle(5);
        check("R4", result, 32'd1);

        // R5 clear then add
        issue(32'd6, 32'd7, 11'd1, 1'b1);
        idle(5);
        check("R5", result, 32'd42);

        // R6 clear only, both bits, reserved bits
        issue(32'd9, 32'd9, 11'd2, 1'b1);
        idle(5);
        check("R6", result, 32'd0);
        issue(32'd5, 32'd5, 11'd0, 1'b1);
        issue(32'd9, 32'd9, 11'd3, 1'b1);
        idle(5);
        check("R6", result, 32'd0);
        issue(32'd2, 32'd2, 11'h7FC, 1'b1);
        idle(5);
        check("R6", result, 32'd4);

        // R2 inputs outside the issuing edge are ignored
        phase_tag = "R2";
        issue(32'd1, 32'd1, 11'd0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            start  = 1'b0;
            dataa  = 32'hDEAD_BEEF;
            datab  = 32'h1234_5678;
            prefix = 11'd3;
        end
        check("R2", result, 32'd5);
        phase_tag = "";

        // R3 clk_en low: ignored start, frozen pipeline
        issue(32'd100, 32'd100, 11'd1, 1'b0);
        idle(5);
        check("R3", result, 32'd5);
        issue(32'd10, 32'd10, 11'd0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start  = 1'b0;
            clk_en = 1'b0;
        end
        check("R3", result, 32'd5);
        idle(4);
        check("R3", result, 32'd105);

        // R8 back-to-back with a clear in the middle
        phase_tag = "R8";
        issue(32'd2, 32'd3, 11'd0, 1'b1);
        issue(32'd4, 32'd4, 11'd0, 1'b1);
        issue(32'd1, 32'd9, 11'd1, 1'b1);
        issue(32'd3, 32'd3, 11'd0, 1'b1);
        issue(32'd7, 32'd7, 11'd2, 1'b1);
        issue(32'd2, 32'd2, 11'd0, 1'b1);
        idle(5);
        check("R8", result, 32'd4);
        phase_tag = "";

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            clk_en = ($urandom_range(3) != 0);
            start  = ($urandom_range(1) == 1);
            garble();
            if ($urandom_range(7) != 0) prefix[1:0] = 2'b00;
        end
        idle(5);

        // R1 reset mid-run flushes pipeline
        issue(32'd11, 32'd11, 11'd0, 1'b1);
        do_reset();
        check("R1", result, 32'd0);
        idle(5);
        check("R1", result, 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog result=%h expected=finish", result);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule